// File: doc/BRIEF.md
# Host Bridge Configuration Space

This block holds the 256-byte configuration space of a single-function host bridge. A byte-wide access port carries a function number, an offset, a write enable and write data. Read data comes back in the same cycle. Only function 0 is implemented. Every byte wakes up at a fixed default after a full reset. The identity, revision, class and header-type bytes ignore writes.

Seven bytes starting at offset 0x59 hold memory-region attribute nibbles. They are exported as a flat bus to a separate address decoder. When a write actually alters one of these nibbles, the block raises a one-cycle change strobe for that region, so the decoder knows to re-evaluate its map. A separate bus-reset input clears the top-region attribute byte at 0x59 and leaves everything else in place.

The access port has no valid/ready handshake and no back-pressure. Every access is accepted and finishes in the cycle it is presented, so the port can never stall a caller. The change strobes are plain pulses, and a consumer must sample them in the cycle they appear.

Top module: `hb_cfg_space`

## Requirements
- R1: When `cfg_func` is nonzero, a write changes no byte and raises no strobe, and `cfg_rdata` reads 0xFF.
- R2: Writes to offsets 0x00, 0x01, 0x02, 0x03, 0x08, 0x09, 0x0A, 0x0B and 0x0E are dropped. A function-0 write to any other offset stores the byte.
- R3: After a full reset, offsets 0x00 to 0x0B read 86 80 30 70 06 00 00 02 00 00 00 06 (hex, ascending offset).
- R4: After a full reset, 0x52=42, 0x53=14, 0x56=52, 0x57=01, 0x60 through 0x64=02, 0x67=11, 0x69=03, 0x70=20, 0x72=02, 0x74=0E and 0x78=23 (hex). Every other offset reads 00.
- R5: `attr_bytes[8k+7:8k]` always equals the stored byte at offset 0x59+k, for k from 0 to 6.
- R6: Strobe bit 0 belongs to bits 7:4 of 0x59. For k from 1 to 6, bit 2k-1 belongs to bits 3:0 and bit 2k belongs to bits 7:4 of offset 0x59+k. A bit is raised only when the value written differs from the stored value in that nibble. Bits 3:0 of 0x59 never raise a strobe.
- R7: A strobe is high for exactly the one cycle after the clock edge that performs the write.
- R8: `shadow_rom` equals bit 4 of offset 0x59.
- R9: A cycle with `bus_rst` high writes 0x00 to offset 0x59 and no other byte. It raises strobe bit 0 if bits 7:4 of 0x59 were nonzero. It takes priority over a function-0 write to 0x59 in the same cycle.
- R10: `cfg_rdata` is combinational from the stored array. A read in the same cycle as a write to that offset returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, loads all defaults |
| bus_rst | input | 1 | Synchronous bus reset, clears offset 0x59 |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Byte offset for read and write |
| cfg_we | input | 1 | Write enable |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read byte, same cycle |
| attr_bytes | output | 56 | Attribute bytes 0x59..0x5F, byte k at bits 8k+7:8k |
| region_chg | output | 13 | One-cycle per-nibble change strobes |
| shadow_rom | output | 1 | Top-region read-enable flag |

## Verification
The bench builds the block with its default parameters: a 3-bit function number, 8-bit offsets, the attribute window at 0x59 and seven attribute bytes. With these values every one of the 256 offsets can be read back against its reset default. All thirteen strobe positions can be reached, and nonzero function numbers up to 7 can be used against both protected and attribute offsets. A reference byte array in the bench predicts every read, strobe vector and exported attribute byte. Each access is issued in consecutive cycles, so strobes from back-to-back writes are also checked for their one-cycle width.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

  // Power-on value of each configuration byte
  function automatic logic [7:0] cfg_default(input logic [7:0] a);
    case (a)
      8'h00: return 8'h86;
      8'h01: return 8'h80;
      8'h02: return 8'h30;
      8'h03: return 8'h70;
      8'h04: return 8'h06;
      8'h07: return 8'h02;
      8'h0B: return 8'h06;
      8'h52: return 8'h42;
      8'h53: return 8'h14;
      8'h56: return 8'h52;
      8'h57: return 8'h01;
      8'h60, 8'h61, 8'h62, 8'h63, 8'h64: return 8'h02;
      8'h67: return 8'h11;
      8'h69: return 8'h03;
      8'h70: return 8'h20;
      8'h72: return 8'h02;
      8'h74: return 8'h0E;
      8'h78: return 8'h23;
      default: return 8'h00;
    endcase
  endfunction

  // Bytes that never accept a write (identity, revision, class, header type)
  function automatic logic cfg_locked(input logic [7:0] a);
    return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E);
  endfunction

endpackage

// File: rtl/hb_cfg_store.sv
module hb_cfg_store
  import hb_cfg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ATTR_BASE  = 'h59,
  parameter int ATTR_BYTES = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wr_data,
  output logic [7:0]              rd_data,
  output logic [ATTR_BYTES*8-1:0] attr_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP_IDX = ADDR_W'(ATTR_BASE);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= cfg_default(8'(i));
    end else begin
      if (wr_en && !cfg_locked(8'(addr))) mem[addr] <= wr_data;
      if (bus_rst) mem[TOP_IDX] <= 8'h00;   // bus reset wins
    end
  end

  assign rd_data = mem[addr];

  for (genvar k = 0; k < ATTR_BYTES; k++) begin : g_attr
    assign attr_o[8*k +: 8] = mem[ATTR_BASE + k];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_lock
    if (cfg_locked(8'(i))) begin : g_chk
      AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mem[i])); // R2
    end
  end

  AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (mem[TOP_IDX] == 8'h00)); // R9

endmodule

// File: rtl/hb_cfg_chg.sv
module hb_cfg_chg #(
  parameter int ADDR_W     = 8,
  parameter int ATTR_BASE  = 'h59,
  parameter int ATTR_BYTES = 7,
  localparam int NIBS      = 2 * ATTR_BYTES - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ATTR_BYTES*8-1:0] attr_cur,
  output logic [NIBS-1:0]         chg_o
);
  logic [NIBS-1:0] chg_nxt;

  // Strobe j watches nibble j+1 of the flat attribute bus
  for (genvar j = 0; j < NIBS; j++) begin : g_nib
    localparam int BY = (j + 1) / 2;
    localparam int HI = (j + 1) % 2;
    logic       by_rst;
    logic       hit;
    logic [3:0] new_nib;
    assign by_rst  = bus_rst && (BY == 0);
    assign hit     = by_rst || (wr_en && (wr_addr == ADDR_W'(ATTR_BASE + BY)));
    assign new_nib = by_rst ? 4'h0 : wr_data[4*HI +: 4];
    assign chg_nxt[j] = hit && (new_nib != attr_cur[4*(j+1) +: 4]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_o <= '0;
    else        chg_o <= chg_nxt;
  end

  for (genvar j = 0; j < NIBS; j++) begin : g_ast
    AST_PULSE_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      chg_o[j] |-> (attr_cur[4*(j+1) +: 4] != $past(attr_cur[4*(j+1) +: 4]))); // R6
  end

endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hb_cfg_pkg::*;
#(
  parameter int FUNC_W     = 3,
  parameter int ADDR_W     = 8,
  parameter int ATTR_BASE  = 'h59,
  parameter int ATTR_BYTES = 7,
  localparam int NIBS      = 2 * ATTR_BYTES - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_rst,
  input  logic [FUNC_W-1:0]       cfg_func,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_wdata,
  output logic [7:0]              cfg_rdata,
  output logic [ATTR_BYTES*8-1:0] attr_bytes,
  output logic [NIBS-1:0]         region_chg,
  output logic                    shadow_rom
);
  logic       fn0;
  logic       wr_en;
  logic [7:0] store_rd;

  assign fn0   = (cfg_func == '0);
  assign wr_en = cfg_we && fn0;

  hb_cfg_store #(
    .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE), .ATTR_BYTES(ATTR_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_en(wr_en),
    .addr(cfg_addr), .wr_data(cfg_wdata), .rd_data(store_rd), .attr_o(attr_bytes)
  );

  hb_cfg_chg #(
    .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE), .ATTR_BYTES(ATTR_BYTES)
  ) u_chg (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_en(wr_en),
    .wr_addr(cfg_addr), .wr_data(cfg_wdata), .attr_cur(attr_bytes), .chg_o(region_chg)
  );

  assign cfg_rdata  = fn0 ? store_rd : 8'hFF;
  assign shadow_rom = attr_bytes[4];

  AST_FUNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !fn0 && !bus_rst) |=> ($stable(attr_bytes) && (region_chg == '0))); // R1

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (region_chg != '0) |-> $past(wr_en || bus_rst)); // R7

endmodule

// File: tb/tb_hb_cfg_space.sv
module tb_hb_cfg_space;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic [2:0]  cfg_func = '0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [55:0] attr_bytes;
  logic [12:0] region_chg;
  logic        shadow_rom;

  hb_cfg_space dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cfg_func(cfg_func),
    .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .attr_bytes(attr_bytes), .region_chg(region_chg),
    .shadow_rom(shadow_rom)
  );

  always #4 clk = ~clk;   // 125 MHz

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    int          kind;   // 0 read, 1 strobes, 2 shadow, 3 attribute bus
    logic [63:0] val;
    string       req;
  } item_t;
  item_t q[$];
  logic [7:0] model [256];

  function automatic logic [7:0] spec_default(input int a);
    if (a >= 'h60 && a <= 'h64) return 8'h02;
    case (a)
      'h00: return 8'h86; 'h01: return 8'h80; 'h02: return 8'h30; 'h03: return 8'h70;
      'h04: return 8'h06; 'h07: return 8'h02; 'h0B: return 8'h06;
      'h52: return 8'h42; 'h53: return 8'h14; 'h56: return 8'h52; 'h57: return 8'h01;
      'h67: return 8'h11; 'h69: return 8'h03; 'h70: return 8'h20; 'h72: return 8'h02;
      'h74: return 8'h0E; 'h78: return 8'h23;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit spec_locked(input int a);
    return (a <= 3) || (a >= 8 && a <= 'h0B) || (a == 'h0E);
  endfunction

  task automatic push(input int at, input int kind, input logic [63:0] v, input string req);
    item_t it;
    it.at = at; it.kind = kind; it.val = v; it.req = req;
    q.push_back(it);
  endtask

  // Driver: one access per cycle, expectations from the reference array
  task automatic op(input logic [2:0] f, input int a, input bit we,
                    input logic [7:0] d, input bit br, input string req);
    int n;
    logic [12:0] chg;
    logic [55:0] attr;
    logic [7:0] nv;
    @(posedge clk); #1;
    cfg_func = f; cfg_addr = 8'(a); cfg_we = we; cfg_wdata = d; bus_rst = br;
    n = cyc;
    for (int k = 0; k < 7; k++) attr[8*k +: 8] = model['h59 + k];
    push(n, 0, (f != 0) ? 64'hFF : 64'(model[a]), req);
    push(n, 2, 64'(model['h59][4]), "R8");
    push(n, 3, 64'(attr), "R5");
    chg = '0;
    for (int j = 0; j < 13; j++) begin
      int by = (j + 1) / 2;
      int hi = (j + 1) % 2;
      bit hit = (we && f == 0 && a == 'h59 + by) || (br && by == 0);
      nv = (br && by == 0) ? 8'h00 : d;
      if (hit && (nv[4*hi +: 4] != model['h59 + by][4*hi +: 4])) chg[j] = 1'b1;
    end
    if (we && f == 0 && !spec_locked(a)) model[a] = d;
    if (br) model['h59] = 8'h00;
    push(n + 1, 1, 64'(chg), "R6 R7");
  endtask

  task automatic idle();
    @(posedge clk); #1;
    cfg_we = 1'b0; bus_rst = 1'b0; cfg_func = '0;
  endtask

  // Monitor: pop expectations as their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = 64'(cfg_rdata);
        1: act = 64'(region_chg);
        2: act = 64'(shadow_rom);
        default: act = 64'(attr_bytes);
      endcase
      total++;
      if (it.at != cyc || act !== it.val) begin
        bad++;
        $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h", it.req, it.kind, cyc, act, it.val);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = spec_default(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3 R4: every default
    for (int i = 0; i < 256; i++) op(0, i, 0, 8'h00, 0, (i < 12) ? "R3" : "R4");
    // R2: protected and open bytes (the write cycle also checks R10)
    op(0, 'h00, 1, 8'h55, 0, "R10"); op(0, 'h00, 0, 0, 0, "R2");
    op(0, 'h0B, 1, 8'hEE, 0, "R10"); op(0, 'h0B, 0, 0, 0, "R2");
    op(0, 'h0E, 1, 8'h7F, 0, "R10"); op(0, 'h0E, 0, 0, 0, "R2");
    op(0, 'h09, 1, 8'h12, 0, "R10"); op(0, 'h09, 0, 0, 0, "R2");
    op(0, 'h04, 1, 8'h07, 0, "R10"); op(0, 'h04, 0, 0, 0, "R2");
    op(0, 'h0C, 1, 8'h10, 0, "R10"); op(0, 'h0C, 0, 0, 0, "R2");
    // R1: other function numbers
    op(1, 'h40, 1, 8'hAA, 0, "R1"); op(0, 'h40, 0, 0, 0, "R1");
    op(5, 'h00, 0, 0, 0, "R1");
    op(7, 'h5A, 1, 8'hFF, 0, "R1"); op(0, 'h5A, 0, 0, 0, "R1");
    // R6 R7: strobes per nibble, back to back
    op(0, 'h5A, 1, 8'h31, 0, "R10"); op(0, 'h5A, 1, 8'h31, 0, "R6");
    op(0, 'h5A, 1, 8'h21, 0, "R6");  op(0, 'h59, 1, 8'h0F, 0, "R6");
    op(0, 'h59, 1, 8'h3F, 0, "R8");  op(0, 'h5F, 1, 8'h90, 0, "R6");
    op(0, 'h5C, 1, 8'h05, 0, "R6");  op(0, 'h5E, 1, 8'hFF, 0, "R6");
    op(0, 'h5B, 0, 0, 0, "R7");      op(0, 'h59, 1, 8'h2E, 0, "R8");
    op(0, 'h59, 0, 0, 0, "R8");
    // R9: bus reset
    op(0, 'h60, 1, 8'h77, 0, "R9");  op(0, 'h59, 1, 8'h5F, 0, "R9");
    op(0, 'h59, 0, 0, 1, "R9");      op(0, 'h59, 0, 0, 0, "R9");
    op(0, 'h5A, 0, 0, 0, "R9");      op(0, 'h60, 0, 0, 0, "R9");
    op(0, 'h59, 0, 0, 1, "R9");
    op(0, 'h59, 1, 8'h50, 0, "R9");  op(0, 'h59, 1, 8'hA0, 1, "R9");
    op(0, 'h59, 0, 0, 0, "R9");
    op(0, 'h59, 1, 8'h0C, 1, "R9");  op(0, 'h59, 0, 0, 0, "R9");
    idle();
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard left %0d items actual=%0d expected=0", q.size(), q.size());
    end
    finish_run();
  end
endmodule